// File: doc/BRIEF.md
# Configurable Bit-Stream FIFO

This block is a first-in first-out queue whose unit of storage is a single bit rather than a word. A producer hands it data words. Each word is accepted together with a standing write setting, which chooses how many bits of the word enter the queue and in which order. A consumer pulls words out. A standing read setting tells the block how many head bits to throw away, how many following bits to gather into the low end of the returned word, and whether to fill the upper bits of that word from the last gathered bit.

The write and read settings are registers. Each one is loaded by a single-cycle strobe and stays in force for every later transfer until it is loaded again. The queue holds two data words' worth of bits. Producer and consumer each use a valid/ready pair. The ready and valid outputs depend only on the current fill level and the settings, so a transfer never waits on the other side. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `bitstream_fifo`

## Requirements
- R1: After reset the queue is empty, so `rd_valid` is 0. Both settings return to a count of 1, no discard, no fill and lsb-first order, so `wr_ready` is 1 and a single queued 1 bit reads back as the word 1.
- R2: A word is accepted (`wr_valid` and `wr_ready` both high at a clock edge) only when the free space, 74 minus the bits held, is at least the write count. A full queue holds exactly 74 bits.
- R3: With the lsb-first flag at 1, bit 0 of the word is queued first, then bit 1, and so on up to bit count-1.
- R4: With the lsb-first flag at 0, the low count bits of the word are queued from bit count-1 down to bit 0.
- R5: `rd_valid` is 1 exactly when the bits held are at least the discard count plus the read count.
- R6: The n-th bit gathered after the discard appears at `rd_data` bit n-1. With the fill flag at 0, every bit from the read count upward is 0.
- R7: A completed read removes the discard count of head bits, and those bits never appear in `rd_data`, and then removes the gathered bits.
- R8: With the fill flag at 1, every `rd_data` bit from the read count upward equals the last gathered bit.
- R9: A loaded setting applies to every transfer from the next clock edge on, and it is reused until the setting is loaded again.
- R10: Count codes are bounded when a setting is loaded. A write or read count of 0 acts as 1, and a count or discard above 37 acts as 37.
- R11: A read and a write may complete at the same edge. Write space is judged on the fill level before that edge's read, so a full queue refuses a word even while it is being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wop_load | input | 1 | Load the write setting |
| wop_take | input | 6 | Write bit count code |
| wop_lsb_first | input | 1 | 1: word bit 0 queued first |
| rop_load | input | 1 | Load the read setting |
| rop_drop | input | 6 | Read discard count code |
| rop_take | input | 6 | Read bit count code |
| rop_sext | input | 1 | 1: fill upper bits from last gathered bit |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | Space for the current write count |
| wr_data | input | 37 | Producer word |
| rd_valid | output | 1 | Enough bits for the current read setting |
| rd_ready | input | 1 | Consumer takes `rd_data` |
| rd_data | output | 37 | Gathered bit field |

## Verification
A setting strobed at one rising edge governs the transfers sampled after that edge. Each transfer changes the fill level and the head of the queue at the edge where it completes. `rd_valid`, `rd_data` and `wr_ready` are combinational views of registered state, so the effect of an edge can be seen at any point before the next edge. The bench changes inputs at falling edges and samples outputs one time unit later. Every result it reads therefore belongs to the state left by the previous rising edge, and the inputs it has just applied, such as the ones in the simultaneous read-and-write case, have not yet been committed.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  localparam int unsigned BSF_DATA_W      = 37;
  localparam int unsigned BSF_DEPTH_WORDS = 2;

  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;
endpackage

// File: rtl/bsf_op_regs.sv
module bsf_op_regs #(
  parameter int unsigned W     = 37,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wop_load,
  input  logic [CNT_W-1:0] wop_take,
  input  logic             wop_lsb_first,
  input  logic             rop_load,
  input  logic [CNT_W-1:0] rop_drop,
  input  logic [CNT_W-1:0] rop_take,
  input  logic             rop_sext,
  output logic [CNT_W-1:0] wtake_q,
  output logic             wlsb_q,
  output logic [CNT_W-1:0] rdrop_q,
  output logic [CNT_W-1:0] rtake_q,
  output logic             rsext_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // bound a count code; zero_ok selects whether 0 is kept
  function automatic logic [CNT_W-1:0] bound_cnt(input logic [CNT_W-1:0] v,
                                                 input logic zero_ok);
    logic [CNT_W-1:0] r;
    r = v;
    if (v > CNT_MAX) r = CNT_MAX;
    else if (!zero_ok && (v == '0)) r = CNT_ONE;
    return r;
  endfunction

  logic [CNT_W-1:0] wtake_d, rdrop_d, rtake_d;
  logic             wlsb_d, rsext_d;

  always_comb begin
    wtake_d = bound_cnt(wop_take, 1'b0);
    wlsb_d  = wop_lsb_first;
    rdrop_d = bound_cnt(rop_drop, 1'b1);
    rtake_d = bound_cnt(rop_take, 1'b0);
    rsext_d = rop_sext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wtake_q <= CNT_ONE;
      wlsb_q  <= bsf_pkg::ORDER_LSB;
    end else if (wop_load) begin
      wtake_q <= wtake_d;
      wlsb_q  <= wlsb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdrop_q <= '0;
      rtake_q <= CNT_ONE;
      rsext_q <= 1'b0;
    end else if (rop_load) begin
      rdrop_q <= rdrop_d;
      rtake_q <= rtake_d;
      rsext_q <= rsext_d;
    end
  end
endmodule

// File: rtl/bsf_wr_pack.sv
module bsf_wr_pack #(
  parameter int unsigned W     = 37,
  parameter int unsigned CNT_W = 6
) (
  input  logic [W-1:0]     data,
  input  logic [CNT_W-1:0] take,
  input  logic             lsb_first,
  output logic [W-1:0]     bits
);
  logic [W-1:0]     rev;
  logic [W-1:0]     mask;
  logic [CNT_W-1:0] gap;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev[g] = data[W-1-g];
  end

  always_comb begin
    gap  = CNT_W'(W) - take;
    mask = {W{1'b1}} >> gap;
    if (bsf_pkg::bit_order_e'(lsb_first) == bsf_pkg::ORDER_LSB) begin
      bits = data & mask;
    end else begin
      bits = rev >> gap;
    end
  end
endmodule

// File: rtl/bsf_rd_extract.sv
module bsf_rd_extract #(
  parameter int unsigned W     = 37,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned CAP   = 74
) (
  input  logic [CAP-1:0]   store,
  input  logic [CNT_W-1:0] drop,
  input  logic [CNT_W-1:0] take,
  input  logic             sext,
  output logic [W-1:0]     word
);
  logic [W-1:0] low_w, mask, top_bit, field;
  logic         sign;

  always_comb begin
    low_w   = W'(store >> drop);
    mask    = {W{1'b1}} >> (CNT_W'(W) - take);
    top_bit = mask ^ (mask >> 1);
    field   = low_w & mask;
    sign    = |(field & top_bit);
    word    = (sext && sign) ? (field | ~mask) : field;
  end
endmodule

// File: rtl/bitstream_fifo.sv
module bitstream_fifo #(
  parameter int unsigned DATA_W      = bsf_pkg::BSF_DATA_W,
  parameter int unsigned DEPTH_WORDS = bsf_pkg::BSF_DEPTH_WORDS,
  parameter int unsigned CNT_W       = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wop_load,
  input  logic [CNT_W-1:0]  wop_take,
  input  logic              wop_lsb_first,
  input  logic              rop_load,
  input  logic [CNT_W-1:0]  rop_drop,
  input  logic [CNT_W-1:0]  rop_take,
  input  logic              rop_sext,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned CAP   = DATA_W * DEPTH_WORDS;
  localparam int unsigned OCC_W = $clog2(CAP + 1);
  localparam logic [OCC_W-1:0] CAP_V = OCC_W'(CAP);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // standing settings
  logic [CNT_W-1:0] wtake_q, rdrop_q, rtake_q;
  logic             wlsb_q, rsext_q;

  bsf_op_regs #(.W(DATA_W), .CNT_W(CNT_W)) u_ops (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wop_load      (wop_load),
    .wop_take      (wop_take),
    .wop_lsb_first (wop_lsb_first),
    .rop_load      (rop_load),
    .rop_drop      (rop_drop),
    .rop_take      (rop_take),
    .rop_sext      (rop_sext),
    .wtake_q       (wtake_q),
    .wlsb_q        (wlsb_q),
    .rdrop_q       (rdrop_q),
    .rtake_q       (rtake_q),
    .rsext_q       (rsext_q)
  );

  // bit storage: head of queue at bit 0, bits at and above occ_q are zero
  logic [CAP-1:0]   store_q, store_mid, store_d;
  logic [OCC_W-1:0] occ_q, occ_mid, occ_d;
  logic [OCC_W-1:0] rd_need;
  logic [DATA_W-1:0] wbits;
  logic             rd_fire, wr_fire, st_en;

  bsf_wr_pack #(.W(DATA_W), .CNT_W(CNT_W)) u_pack (
    .data      (wr_data),
    .take      (wtake_q),
    .lsb_first (wlsb_q),
    .bits      (wbits)
  );

  bsf_rd_extract #(.W(DATA_W), .CNT_W(CNT_W), .CAP(CAP)) u_extract (
    .store (store_q),
    .drop  (rdrop_q),
    .take  (rtake_q),
    .sext  (rsext_q),
    .word  (rd_data)
  );

  always_comb begin
    rd_need  = OCC_W'(rdrop_q) + OCC_W'(rtake_q);
    rd_valid = (occ_q >= rd_need);
    wr_ready = ((CAP_V - occ_q) >= OCC_W'(wtake_q));
    rd_fire  = rd_valid && rd_ready;
    wr_fire  = wr_valid && wr_ready;
    st_en    = rd_fire || wr_fire;

    store_mid = store_q;
    occ_mid   = occ_q;
    if (rd_fire) begin
      store_mid = store_q >> rd_need;
      occ_mid   = occ_q - rd_need;
    end

    store_d = store_mid;
    occ_d   = occ_mid;
    if (wr_fire) begin
      store_d = store_mid | (CAP'(wbits) << occ_mid);
      occ_d   = occ_mid + OCC_W'(wtake_q);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      store_q <= '0;
      occ_q   <= '0;
    end else if (st_en) begin
      store_q <= store_d;
      occ_q   <= occ_d;
    end
  end
endmodule

// File: rtl/bitstream_fifo_chk.sv
module bitstream_fifo_chk #(
  parameter int unsigned W     = 37,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned CAP   = 74,
  parameter int unsigned OCC_W = 7
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [W-1:0]     rd_data,
  input logic             rop_load,
  input logic [OCC_W-1:0] occ_q,
  input logic [CNT_W-1:0] wtake_q,
  input logic [CNT_W-1:0] rdrop_q,
  input logic [CNT_W-1:0] rtake_q,
  input logic             rsext_q
);
  logic rdf, wrf;
  assign rdf = rd_valid && rd_ready;
  assign wrf = wr_valid && wr_ready;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    occ_q <= OCC_W'(CAP));

  p_wr_grow_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wrf && !rdf) |=> (occ_q == $past(occ_q) + OCC_W'($past(wtake_q))));

  p_rd_shrink_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rdf && !wrf) |=> ((occ_q + OCC_W'($past(rdrop_q)) + OCC_W'($past(rtake_q)))
                       == $past(occ_q)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rdf && !wrf) |=> $stable(occ_q));

  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && !rsext_q) |-> ((rd_data >> rtake_q) == '0));

  p_op_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rop_load |=> $stable({rdrop_q, rtake_q, rsext_q}));

  p_count_range_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wtake_q != '0) && (rtake_q != '0) && (rtake_q <= CNT_W'(W)) && (rdrop_q <= CNT_W'(W)));
endmodule

bind bitstream_fifo bitstream_fifo_chk #(
  .W(DATA_W), .CNT_W(CNT_W), .CAP(CAP), .OCC_W(OCC_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .rop_load   (rop_load),
  .occ_q      (occ_q),
  .wtake_q    (wtake_q),
  .rdrop_q    (rdrop_q),
  .rtake_q    (rtake_q),
  .rsext_q    (rsext_q)
);

// File: tb/bitstream_fifo_tb_top.sv
module bitstream_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 37;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wop_load = 1'b0, wop_lsb_first = 1'b1;
  logic [5:0]    wop_take = 6'd1;
  logic          rop_load = 1'b0, rop_sext = 1'b0;
  logic [5:0]    rop_drop = 6'd0, rop_take = 6'd1;
  logic          wr_valid = 1'b0, rd_ready = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          wr_ready, rd_valid;
  logic [W-1:0]  rd_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitstream_fifo dut_i (
    .clk(clk), .rst_n(rst_n),
    .wop_load(wop_load), .wop_take(wop_take), .wop_lsb_first(wop_lsb_first),
    .rop_load(rop_load), .rop_drop(rop_drop), .rop_take(rop_take), .rop_sext(rop_sext),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  // {is_read, take, drop, flag, data, expected}
  localparam logic [87:0] VEC [NV] = '{
    {1'b0, 6'd8,  6'd0, 1'b1, 37'hA5,           37'h0},            // R3 lsb-first
    {1'b0, 6'd4,  6'd0, 1'b0, 37'h3,            37'h0},            // R4 msb-first
    {1'b1, 6'd4,  6'd0, 1'b0, 37'h0,            37'h5},            // R6
    {1'b1, 6'd3,  6'd2, 1'b1, 37'h0,            37'h2},            // R7 R8 sign 0
    {1'b0, 6'd37, 6'd0, 1'b1, 37'h10_0000_0001, 37'h0},            // R3 full word
    {1'b1, 6'd3,  6'd1, 1'b1, 37'h0,            37'h1F_FFFF_FFFF}, // R8 sign 1
    {1'b1, 6'd36, 6'd0, 1'b1, 37'h0,            37'h18_0000_0000}, // R8 R4 tail
    {1'b0, 6'd5,  6'd0, 1'b1, 37'h1F,           37'h0},
    {1'b1, 6'd5,  6'd0, 1'b0, 37'h0,            37'h1F}            // R6
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_wop(input logic [5:0] t, input logic lsb);
    @(negedge clk);
    wop_load = 1'b1; wop_take = t; wop_lsb_first = lsb;
    @(negedge clk);
    wop_load = 1'b0;
  endtask

  task automatic load_rop(input logic [5:0] d, input logic [5:0] t, input logic s);
    @(negedge clk);
    rop_load = 1'b1; rop_drop = d; rop_take = t; rop_sext = s;
    @(negedge clk);
    rop_load = 1'b0;
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    #1 chk("R2 wr_ready before push", W'(wr_ready), W'(1));
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop(input string tag, input logic [W-1:0] exp);
    @(negedge clk);
    rd_ready = 1'b1;
    #1 chk({tag, " rd_valid"}, W'(rd_valid), W'(1));
    chk({tag, " rd_data"}, rd_data, exp);
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R1 empty after reset", W'(rd_valid), W'(0));
    chk("R1 wr_ready after reset", W'(wr_ready), W'(1));

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][87] == 1'b0) begin
        load_wop(VEC[i][86:81], VEC[i][74]);
        push(VEC[i][73:37]);
      end else begin
        load_rop(VEC[i][80:75], VEC[i][86:81], VEC[i][74]);
        pop($sformatf("R6/R7/R8 vector %0d", i), VEC[i][36:0]);
      end
    end
    #1 chk("R7 empty after table", W'(rd_valid), W'(0));

    // R5: discard plus count gate
    load_rop(6'd2, 6'd3, 1'b0);
    #1 chk("R5 empty not valid", W'(rd_valid), W'(0));
    load_wop(6'd4, 1'b1);
    push(37'hA);
    #1 chk("R5 four of five bits", W'(rd_valid), W'(0));
    load_wop(6'd1, 1'b1);
    push(37'h1);
    #1 chk("R5 five bits valid", W'(rd_valid), W'(1));
    pop("R5 R7 discard then take", 37'h6);

    // R9: settings reused
    load_wop(6'd3, 1'b1);
    push(37'h5);
    push(37'h3);
    load_rop(6'd0, 6'd3, 1'b0);
    pop("R9 first reuse", 37'h5);
    pop("R9 second reuse", 37'h3);

    // R10: zero counts act as one
    load_wop(6'd0, 1'b1);
    push(37'h1F_FFFF_FFFF);
    load_rop(6'd0, 6'd0, 1'b0);
    pop("R10 zero count as one", 37'h1);
    #1 chk("R10 one bit consumed", W'(rd_valid), W'(0));

    // R2/R11/R10: full queue
    load_wop(6'd37, 1'b1);
    push(37'h5);
    push(37'h10_0000_0003);
    #1 chk("R2 full refuses 37", W'(wr_ready), W'(0));
    load_wop(6'd1, 1'b1);
    #1 chk("R2 full refuses 1", W'(wr_ready), W'(0));
    load_rop(6'd63, 6'd63, 1'b1);
    #1 chk("R10 clamped 74 valid", W'(rd_valid), W'(1));
    chk("R10 clamped field", rd_data, 37'h10_0000_0003);
    @(negedge clk);
    rd_ready = 1'b1; wr_valid = 1'b1; wr_data = 37'h1;
    #1 chk("R11 no space during read", W'(wr_ready), W'(0));
    @(negedge clk);
    rd_ready = 1'b0; wr_valid = 1'b0;
    #1 chk("R11 emptied", W'(rd_valid), W'(0));
    chk("R11 space back", W'(wr_ready), W'(1));

    // R11: both fire at one edge
    load_rop(6'd0, 6'd1, 1'b0);
    push(37'h1);
    @(negedge clk);
    rd_ready = 1'b1; wr_valid = 1'b1; wr_data = 37'h0;
    #1 chk("R11 head before", rd_data, 37'h1);
    chk("R11 write ready", W'(wr_ready), W'(1));
    @(negedge clk);
    rd_ready = 1'b0; wr_valid = 1'b0;
    #1 chk("R11 new head", rd_data, 37'h0);
    chk("R11 one bit left", W'(rd_valid), W'(1));

    // R1: reset mid-run
    load_wop(6'd5, 1'b1);
    push(37'h1F);
    load_rop(6'd3, 6'd9, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R1 emptied by reset", W'(rd_valid), W'(0));
    chk("R1 ready after reset", W'(wr_ready), W'(1));
    push(37'h1F_FFFF_FFFF);
    pop("R1 default settings", 37'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule